// File: doc/BRIEF.md
# Line Time Clock Gate

This block owns one 16-bit control/status word that governs a periodic event line used by a processor as its line-frequency interrupt source. The event line idles high, and the processor takes an interrupt on each high-to-low transition. The block does not request an interrupt on its own. It only allows the line to toggle or holds it at its idle level.

A static mode input selects where ticks come from. The first source is an internal divider that turns the core clock into a line-rate pulse train with a fixed low time. The second is an external clock input. The third is an event line that another source drives, which this block can only clamp. Both external inputs pass through a two-flop synchronizer.

The word holds two live bits. Bit 6 enables the event line. Bit 7 is a monitor flag that records every tick reaching the line. Software can clear the monitor flag but can never set it. Power-up and the synchronous init pulse both clear the two bits.

Top module: `ltc_ctrl`

## Requirements
- R1: After power-up reset, `rd_data` is 0x0000, `evt_out` is 1 and `clamp` is 0.
- R2: `rd_data` shows the monitor flag at bit 7 and the enable at bit 6. Bits 15..8 and 5..0 always read 0, whatever was written.
- R3: A write (`wr_en` high at a clock edge) loads `wr_data[6]` into the enable bit.
- R4: A write with `wr_data[7]`=0 clears the monitor flag. A write with `wr_data[7]`=1 leaves it unchanged and never sets it.
- R5: Each high-to-low transition of `evt_out` sets the monitor flag on the next clock edge. If a tick and a clearing write arrive on the same edge, the flag ends up set.
- R6: With mode 2'b00 or 2'b11 (internal source) and the enable set, `evt_out` repeats every TICK_DIV cycles and is low for LOW_CYC cycles of each period.
- R7: With mode 2'b01 (external clock) and the enable set, `evt_out` follows `ext_clk` two clock cycles late, so it keeps the period and low time of `ext_clk`.
- R8: With mode 2'b10 (external event line), `clamp` equals the inverse of the enable bit. With the enable set, `evt_out` follows `evt_in` two clock cycles late.
- R9: While the enable is 0, `evt_out` stays 1 in every mode, whatever the inputs do, so the monitor flag cannot be set.
- R10: A cycle with `init` high clears both the enable and the monitor flag on the next edge. It overrides a write or a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the internal divider counts it |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| init | input | 1 | Synchronous bus init; clears the register |
| mode | input | 2 | Source select: 00/11 internal, 01 external clock, 10 external event line |
| ext_clk | input | 1 | External clock source, asynchronous |
| evt_in | input | 1 | Externally driven event line level, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| evt_out | output | 1 | Gated event line, idle high, falling edge means a tick |
| clamp | output | 1 | Hold-down control for an externally driven event line |

## Verification
A wrong enable shows on `evt_out` in the same cycle as a line stuck high or as pulses while disabled. In event mode it also shows on `clamp`. A wrong monitor flag shows on `rd_data[7]` one cycle after the falling edge it should have recorded, or after the write that should have cleared it. A wrong divider shows within two tick periods as a period or low width that differs from TICK_DIV and LOW_CYC. A synchronizer of the wrong depth shows as a follow delay other than two cycles.

// File: rtl/ltc_ctrl.sv
module ltc_ctrl #(
  parameter int TICK_DIV = 833333,
  parameter int LOW_CYC  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic [1:0]  mode,
  input  logic        ext_clk,
  input  logic        evt_in,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        evt_out,
  output logic        clamp
);
  localparam int CW = $clog2(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
  localparam logic [CW-1:0] LOWV = CW'(LOW_CYC);

  logic [CW-1:0] cnt;
  logic [1:0]    ck_sync, ev_sync;
  logic          en, mon, evt_q, src, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sync <= 2'b11;
      ev_sync <= 2'b11;
    end else begin
      ck_sync <= {ck_sync[0], ext_clk};
      ev_sync <= {ev_sync[0], evt_in};
    end

  always_comb
    case (mode)
      2'b01:   src = ck_sync[1];
      2'b10:   src = ev_sync[1];
      default: src = (cnt >= LOWV);
    endcase

  assign evt_out = ~en | src;
  assign clamp   = (mode == 2'b10) & ~en;
  assign fall    = evt_q & ~evt_out;
  assign rd_data = {8'h00, mon, en, 6'b000000};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      evt_q <= 1'b1;
      en    <= 1'b0;
      mon   <= 1'b0;
    end else begin
      evt_q <= evt_out;
      if (init) begin
        en  <= 1'b0;
        mon <= 1'b0;
      end else begin
        if (wr_en) en <= wr_data[6];
        if (fall) mon <= 1'b1;
        else if (wr_en && !wr_data[7]) mon <= 1'b0;
      end
    end

  assert_mon_needs_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_data[7]) |-> $past(evt_q && !evt_out));

  assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (rd_data[7:6] == 2'b00));

  assert_write_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !init) |=> (rd_data[6] == $past(wr_data[6])));

  assert_no_sw_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_data[7] && !(evt_q && !evt_out)) |=> !rd_data[7]);

  assert_held_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[6] |-> evt_out);

  assert_clamp_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |-> (mode == 2'b10 && !rd_data[6]));
endmodule

// File: tb/ltc_ctrl_bench.sv
module ltc_ctrl_bench;
  localparam int DIV = 20;
  localparam int LOW = 4;

  logic clk = 0, rst_n = 0, init = 0, ext_clk = 1, evt_in = 1, wr_en = 0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] wr_data = '0, rd_data;
  logic evt_out, clamp;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ltc_ctrl #(.TICK_DIV(DIV), .LOW_CYC(LOW)) u_ltc_ctrl (
    .clk(clk), .rst_n(rst_n), .init(init), .mode(mode), .ext_clk(ext_clk),
    .evt_in(evt_in), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .evt_out(evt_out), .clamp(clamp));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wait_fall(output int n);
    logic prev;
    n = 0;
    prev = evt_out;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      n++;
      if (prev && !evt_out) return;
      prev = evt_out;
    end
    n = -1;
  endtask

  task automatic measure(output int per, output int lw);
    int n;
    wait_fall(n);
    wait_fall(n);
    lw = 0;
    while (!evt_out && lw < 400) begin @(negedge clk); lw++; end
    wait_fall(n);
    per = lw + n;
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int per, lw, n, bad;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(rd_data == 16'h0000 && evt_out && !clamp, "R1", {rd_data, evt_out, clamp}, 16'h0000 << 2 | 2);

    // R2/R4: sweep writes with enable off; only bit 6 reflects
    for (int v = 0; v < 16; v++) begin
      logic [15:0] d = {v[3:2], 6'h2A, v[1], 1'b0, 6'h15} ^ {8'h00, v[0], 7'h00};
      wr(d);
      chk(rd_data == {8'h00, 1'b0, d[6], 6'h00}, "R2", rd_data, {8'h00, 1'b0, d[6], 6'h00});
      wr(16'h0000);
    end

    // R3 enable with bit 6 only, internal mode
    wr(16'h0040);
    chk(rd_data == 16'h0040 || rd_data == 16'h00C0, "R3", rd_data, 16'h0040);

    // R6 internal period and low width, modes 00 and 11
    for (int m = 0; m < 4; m += 3) begin
      wr(16'h0000); mode = m[1:0]; wr(16'h0040);
      measure(per, lw);
      chk(per == DIV, "R6", per, DIV);
      chk(lw == LOW, "R6", lw, LOW);
    end

    // R5 monitor set after fall; set wins over same-edge clear
    wait_fall(n);
    wr(16'h0040);
    chk(rd_data[7] == 1'b1, "R5", rd_data[7], 1);
    // R4 writing 1 keeps, writing 0 clears
    wr(16'h00C0);
    chk(rd_data == 16'h00C0, "R4", rd_data, 16'h00C0);
    wr(16'h0040);
    chk(rd_data == 16'h0040, "R4", rd_data, 16'h0040);
    wait_fall(n);
    @(negedge clk);
    chk(rd_data[7] == 1'b1, "R5", rd_data[7], 1);

    // R9 disabled: line held, monitor stays clear, in every mode
    for (int m = 0; m < 4; m++) begin
      wr(16'h0000); mode = m[1:0];
      bad = 0;
      for (int i = 0; i < 3 * DIV; i++) begin
        ext_clk = i[2]; evt_in = i[1];
        @(negedge clk);
        if (!evt_out || rd_data[7]) bad++;
      end
      chk(bad == 0, "R9", bad, 0);
      chk(clamp == (m == 2), "R8", clamp, m == 2);
    end

    // R7 external clock: sweep half periods 3..6
    mode = 2'b01;
    ext_clk = 1;
    repeat (4) @(negedge clk);
    wr(16'h0040);
    for (int h = 3; h <= 6; h++) begin
      fork
        begin
          for (int i = 0; i < 12; i++) begin
            ext_clk = 0; repeat (h) @(negedge clk);
            ext_clk = 1; repeat (h) @(negedge clk);
          end
        end
        begin
          measure(per, lw);
          chk(per == 2 * h, "R7", per, 2 * h);
          chk(lw == h, "R7", lw, h);
        end
      join
    end
    // R7 delay: two cycles
    ext_clk = 0;
    @(negedge clk);
    chk(evt_out == 1'b1, "R7", evt_out, 1);
    @(negedge clk);
    chk(evt_out == 1'b0, "R7", evt_out, 0);
    ext_clk = 1;
    repeat (3) @(negedge clk);

    // R8 external event line
    wr(16'h0000);
    mode = 2'b10; evt_in = 1;
    repeat (3) @(negedge clk);
    chk(clamp == 1'b1, "R8", clamp, 1);
    wr(16'h0040);
    chk(clamp == 1'b0 && evt_out == 1'b1, "R8", {clamp, evt_out}, 1);
    evt_in = 0;
    @(negedge clk);
    chk(evt_out == 1'b1, "R8", evt_out, 1);
    @(negedge clk);
    chk(evt_out == 1'b0, "R8", evt_out, 0);
    @(negedge clk);
    chk(rd_data == 16'h00C0, "R5", rd_data, 16'h00C0);
    evt_in = 1;
    repeat (2) @(negedge clk);
    chk(evt_out == 1'b1, "R8", evt_out, 1);

    // R10 init overrides a same-edge write
    init = 1; wr_en = 1; wr_data = 16'h00C0;
    @(negedge clk);
    init = 0; wr_en = 0;
    chk(rd_data == 16'h0000 && evt_out && clamp, "R10", rd_data, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule